// File: doc/BRIEF.md
# Halfword Breakpoint Comparator Unit

This block watches the instruction fetch address stream and flags a breakpoint when a fetch lands on a halfword that a debugger has armed. It holds a global control register and a parameterised number of comparator slots. All of them are reached through a simple 32-bit register bus. Each slot stores a word address in the low code region and a two-bit field. That field chooses whether the lower halfword, the upper halfword, both or neither of that word trigger a hit.

The compare is purely combinational from the fetch inputs to the hit outputs. A per-slot hit vector and its OR are presented in the same cycle as `fetch_valid`, so the core's halt logic can act on them at once. Writes to the control register take effect only when a key bit is set in the written data. This protects the global enable from stray writes.

Top module: `hw_bkpt_unit`

## Requirements
- R1: After a synchronous reset the global enable and every slot register read as zero (apart from the count field), and no hit is reported.
- R2: The control word (byte offset 0x00) reads the implemented slot count in bits 7:4 and the global enable in bit 0; bit 1 and all other bits read zero, and the count field cannot be written.
- R3: A control write whose data bit 1 (key) is 0 leaves the global enable unchanged; with bit 1 set, bit 0 of the data becomes the global enable.
- R4: Slot i sits at byte offset 0x08 + 4*i; it stores data bits 31:30 (halfword select), 28:2 (word address) and 0 (slot enable), and reads back with bits 29 and 1 as zero.
- R5: No hit is reported while the global enable is 0.
- R6: A slot whose enable bit is 0 never reports a hit.
- R7: Halfword select 00 matches nothing, 01 matches fetches with address bit 1 = 0, 10 matches fetches with address bit 1 = 1, and 11 matches both.
- R8: A slot matches only when fetch address bits 28:2 equal its stored word address; fetch address bit 0 has no effect.
- R9: Fetch addresses with any of bits 31:29 set never hit.
- R10: Offset 0x04, offsets of unimplemented slots and any access with byte address bits 1:0 not zero read as zero and ignore writes.
- R11: With `fetch_valid` low no hit is reported; otherwise bit i of `bkpt_hit_mask` is slot i's match and `bkpt_hit` is the OR of all bits, so several slots may hit together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while bus_sel is high |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch byte address |
| bkpt_hit | output | 1 | Any slot matches the current fetch |
| bkpt_hit_mask | output | NUM_CMP | Per-slot match vector |

## Verification
Cycle by cycle, the assertions check the gating rules. No hit appears while the global enable is off, while `fetch_valid` is low, above the code region, from a disabled slot or from a slot whose select is 00. A keyless control write must leave the enable stable, and one bus access may target at most one register. The exact halfword selection, the address equality, the register layout on read-back, the ignored offsets and simultaneous hits from two slots are not visible to those properties. Only the bench's directed and random scenarios, checked against its own model, can show them.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int unsigned WORD_W       = 32;
    localparam int unsigned CMP_ADDR_W   = 27;
    localparam int unsigned CTRL_WORD    = 0;
    localparam int unsigned FIRST_SLOT   = 2;
    localparam int unsigned MAX_SLOTS    = 15;

    typedef enum logic [1:0] {
        HSEL_NONE = 2'b00,
        HSEL_LOW  = 2'b01,
        HSEL_HIGH = 2'b10,
        HSEL_BOTH = 2'b11
    } half_sel_e;

    typedef struct packed {
        half_sel_e             sel;
        logic [CMP_ADDR_W-1:0] word;
        logic                  en;
    } cmp_cfg_t;

    function automatic logic [WORD_W-1:0] cmp_to_word(cmp_cfg_t c);
        return {c.sel, 1'b0, c.word, 1'b0, c.en};
    endfunction

    function automatic cmp_cfg_t word_to_cmp(logic [WORD_W-1:0] w);
        cmp_cfg_t c;
        c.sel  = half_sel_e'(w[31:30]);
        c.word = w[28:2];
        c.en   = w[0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_to_word(logic en, logic [3:0] cnt);
        return {24'b0, cnt, 3'b000, en};
    endfunction

    function automatic logic ctrl_key(logic [WORD_W-1:0] w);
        return w[1];
    endfunction

    function automatic logic ctrl_en(logic [WORD_W-1:0] w);
        return w[0];
    endfunction

    function automatic logic in_code_region(logic [WORD_W-1:0] a);
        return a[31:29] == 3'b000;
    endfunction

    function automatic logic half_allowed(half_sel_e s, logic upper);
        return upper ? s[1] : s[0];
    endfunction

    function automatic logic slot_matches(cmp_cfg_t c, logic [WORD_W-1:0] a);
        return c.en && in_code_region(a) && (a[28:2] == c.word)
               && half_allowed(c.sel, a[1]);
    endfunction

endpackage

// File: rtl/bkpt_bus_decode.sv
module bkpt_bus_decode
    import bkpt_pkg::*;
#(
    parameter int unsigned NUM_CMP = 4,
    parameter int unsigned ADDR_W  = 7
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            bus_sel,
    input  logic                            bus_write,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [WORD_W-1:0]               ctrl_rdata,
    input  logic [NUM_CMP-1:0][WORD_W-1:0]  slot_rdata,
    output logic                            ctrl_wr,
    output logic [NUM_CMP-1:0]              slot_wr,
    output logic [WORD_W-1:0]               rdata
);
    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              aligned;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    assign ctrl_wr = bus_sel && bus_write && aligned && (widx == WIDX_W'(CTRL_WORD));

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_wr
        assign slot_wr[i] = bus_sel && bus_write && aligned
                            && (widx == WIDX_W'(FIRST_SLOT + i));
    end

    always_comb begin
        rdata = '0;
        if (bus_sel && aligned) begin
            if (widx == WIDX_W'(CTRL_WORD)) rdata = ctrl_rdata;
            for (int i = 0; i < NUM_CMP; i++) begin
                if (widx == WIDX_W'(FIRST_SLOT + i)) rdata = slot_rdata[i];
            end
        end
    end

    // R10: one access reaches at most one register
    assert_single_target_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl_wr, slot_wr}));

endmodule

// File: rtl/bkpt_ctrl_regs.sv
module bkpt_ctrl_regs
    import bkpt_pkg::*;
#(
    parameter int unsigned NUM_CMP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic              glob_en,
    output logic [WORD_W-1:0] rdata
);
    localparam logic [3:0] CNT = 4'(NUM_CMP);

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en <= 1'b0;
        end else if (wr_en && ctrl_key(wdata)) begin
            glob_en <= ctrl_en(wdata);
        end
    end

    assign rdata = ctrl_to_word(glob_en, CNT);

    // R3: a keyless control write leaves the enable alone
    assert_key_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wdata[1]) |=> $stable(glob_en));

endmodule

// File: rtl/bkpt_cmp_slot.sv
module bkpt_cmp_slot
    import bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              glob_en,
    input  logic              fetch_valid,
    input  logic [WORD_W-1:0] fetch_addr,
    output logic [WORD_W-1:0] rdata,
    output logic              hit
);
    cmp_cfg_t cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{sel: HSEL_NONE, word: '0, en: 1'b0};
        end else if (wr_en) begin
            cfg <= word_to_cmp(wdata);
        end
    end

    assign rdata = cmp_to_word(cfg);
    assign hit   = glob_en && fetch_valid && slot_matches(cfg, fetch_addr);

    // R6: a disabled slot is silent
    assert_slot_off_R6: assert property (@(posedge clk) disable iff (rst)
        !rdata[0] |-> !hit);

    // R7: select 00 matches nothing
    assert_sel_none_R7: assert property (@(posedge clk) disable iff (rst)
        (rdata[31:30] == 2'b00) |-> !hit);

endmodule

// File: rtl/hw_bkpt_unit.sv
module hw_bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int unsigned NUM_CMP = 4,
    parameter int unsigned ADDR_W  = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               fetch_valid,
    input  logic [31:0]        fetch_addr,
    output logic               bkpt_hit,
    output logic [NUM_CMP-1:0] bkpt_hit_mask
);
    logic                           ctrl_wr;
    logic [NUM_CMP-1:0]             slot_wr;
    logic [WORD_W-1:0]              ctrl_rdata;
    logic [NUM_CMP-1:0][WORD_W-1:0] slot_rdata;
    logic                           glob_en;

    bkpt_bus_decode #(.NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_decode (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .ctrl_rdata (ctrl_rdata),
        .slot_rdata (slot_rdata),
        .ctrl_wr    (ctrl_wr),
        .slot_wr    (slot_wr),
        .rdata      (bus_rdata)
    );

    bkpt_ctrl_regs #(.NUM_CMP(NUM_CMP)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctrl_wr),
        .wdata   (bus_wdata),
        .glob_en (glob_en),
        .rdata   (ctrl_rdata)
    );

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
        bkpt_cmp_slot u_slot (
            .clk         (clk),
            .rst         (rst),
            .wr_en       (slot_wr[i]),
            .wdata       (bus_wdata),
            .glob_en     (glob_en),
            .fetch_valid (fetch_valid),
            .fetch_addr  (fetch_addr),
            .rdata       (slot_rdata[i]),
            .hit         (bkpt_hit_mask[i])
        );
    end

    assign bkpt_hit = |bkpt_hit_mask;

    // R5: global enable gates every slot
    assert_global_gate_R5: assert property (@(posedge clk) disable iff (rst)
        !glob_en |-> !bkpt_hit);

    // R9: nothing above the code region hits
    assert_code_region_R9: assert property (@(posedge clk) disable iff (rst)
        (fetch_addr[31:29] != 3'b000) |-> (bkpt_hit_mask == '0));

    // R11: idle fetch bus gives no hit
    assert_idle_fetch_R11: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |-> !bkpt_hit);

endmodule

// File: tb/test_hw_bkpt_unit.sv
module test_hw_bkpt_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NCMP       = 4;
    localparam int AW         = 7;
    localparam logic [31:0] SLOT_MASK = 32'hDFFF_FFFD;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_sel = 1'b0;
    logic            bus_write = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            fetch_valid = 1'b0;
    logic [31:0]     fetch_addr = '0;
    logic            bkpt_hit;
    logic [NCMP-1:0] bkpt_hit_mask;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic        glob_m = 1'b0;
    logic [31:0] slot_m [NCMP];

    always #(CLK_PERIOD/2) clk = ~clk;

    hw_bkpt_unit #(.NUM_CMP(NCMP), .ADDR_W(AW)) i_hw_bkpt_unit (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .bkpt_hit(bkpt_hit), .bkpt_hit_mask(bkpt_hit_mask));

    function automatic logic [NCMP-1:0] exp_mask(logic [31:0] a);
        logic [NCMP-1:0] m = '0;
        for (int i = 0; i < NCMP; i++) begin
            m[i] = glob_m && slot_m[i][0] && (a[31:29] == 3'b000)
                   && (a[28:2] == slot_m[i][28:2])
                   && (a[1] ? slot_m[i][31] : slot_m[i][30]);
        end
        return m;
    endfunction

    function automatic logic [31:0] exp_read(logic [AW-1:0] a);
        int w = int'(a[AW-1:2]);
        if (a[1:0] != 2'b00) return 32'h0;
        if (w == 0) return {24'b0, 4'(NCMP), 3'b000, glob_m};
        if (w >= 2 && w < 2 + NCMP) return slot_m[w-2];
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        int w = int'(a[AW-1:2]);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0;
        if (a[1:0] == 2'b00) begin
            if (w == 0 && d[1]) glob_m = d[0];
            else if (w >= 2 && w < 2 + NCMP) slot_m[w-2] = d & SLOT_MASK;
        end
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp_read(a));
        bus_sel = 1'b0;
    endtask

    task automatic ft(input string tag, input logic [31:0] a, input logic v);
        logic [NCMP-1:0] e;
        @(negedge clk);
        fetch_valid = v; fetch_addr = a;
        #1;
        e = v ? exp_mask(a) : '0;
        chk(tag, 32'(bkpt_hit_mask), 32'(e));
        chk(tag, 32'(bkpt_hit), 32'(|e));
        fetch_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NCMP; i++) slot_m[i] = '0;
        void'($urandom(32'h0BAD_5EED));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd("R1 ctrl after reset", 7'h00);
        rd("R1 slot0 after reset", 7'h08);
        rd("R1 slot3 after reset", 7'h14);
        ft("R1 no hit after reset", 32'h0000_0000, 1'b1);

        // R2 count field and key bit read-back
        wr(7'h00, 32'hFFFF_FFF3);
        rd("R2 ctrl count read-only", 7'h00);
        // R3 key gating
        wr(7'h00, 32'h0000_0002);
        rd("R3 keyed disable", 7'h00);
        wr(7'h00, 32'h0000_0001);
        rd("R3 keyless write ignored", 7'h00);
        wr(7'h00, 32'h0000_0003);
        rd("R3 keyed enable", 7'h00);

        // R4 slot layout
        wr(7'h08, 32'hFFFF_FFFF);
        rd("R4 slot0 reserved bits zero", 7'h08);
        wr(7'h0C, 32'h4000_1235);
        rd("R4 slot1 read-back", 7'h0C);

        // R10 ignored offsets
        rd("R10 offset 4 reads zero", 7'h04);
        wr(7'h1C, 32'hFFFF_FFFF);
        rd("R10 unimplemented slot", 7'h1C);
        rd("R10 top offset", 7'h7C);
        wr(7'h0A, 32'h0000_0000);
        rd("R10 misaligned write ignored", 7'h08);
        rd("R10 misaligned read zero", 7'h0B);

        // Directed match set
        wr(7'h08, 32'h4000_1001);
        wr(7'h0C, 32'h8000_2005);
        wr(7'h10, 32'hDFFF_FFFD);
        wr(7'h14, 32'h0000_3001);

        // R7 halfword select
        ft("R7 low sel lower half", 32'h0000_1000, 1'b1);
        ft("R7 low sel upper half", 32'h0000_1002, 1'b1);
        ft("R7 high sel lower half", 32'h0000_2004, 1'b1);
        ft("R7 high sel upper half", 32'h0000_2006, 1'b1);
        ft("R7 both sel lower", 32'h1FFF_FFFC, 1'b1);
        ft("R7 both sel upper", 32'h1FFF_FFFE, 1'b1);
        ft("R7 none sel lower", 32'h0000_3000, 1'b1);
        ft("R7 none sel upper", 32'h0000_3002, 1'b1);

        // R8 address compare
        ft("R8 bit0 ignored", 32'h0000_1001, 1'b1);
        ft("R8 next word misses", 32'h0000_1004, 1'b1);

        // R9 code region limit
        ft("R9 bit29 set", 32'h3FFF_FFFC, 1'b1);
        ft("R9 above region", 32'h2000_1000, 1'b1);
        ft("R9 high region", 32'hE000_1000, 1'b1);

        // R11 valid gating and multiple hits
        ft("R11 fetch_valid low", 32'h0000_1000, 1'b0);
        wr(7'h14, 32'h4000_1001);
        ft("R11 two slots hit", 32'h0000_1000, 1'b1);

        // R6 slot enable
        wr(7'h08, 32'h4000_1000);
        ft("R6 disabled slot", 32'h0000_1000, 1'b1);

        // R5 global enable
        wr(7'h00, 32'h0000_0002);
        ft("R5 global off", 32'h0000_1000, 1'b1);
        wr(7'h00, 32'h0000_0003);
        ft("R5 global back on", 32'h0000_1000, 1'b1);

        // Random mix (R3 R4 R7 R8 R9 R10 R11)
        for (int n = 0; n < 400; n++) begin
            int op = int'($urandom % 4);
            if (op == 0) begin
                logic [AW-1:0] a = AW'(($urandom % 8) * 4);
                logic [31:0] d = $urandom;
                if (a == 0) d[1] = ($urandom % 4) != 0;
                else d[31:29] = {d[31:30], 1'b0};
                if (a != 0) d[0] = ($urandom % 4) != 0;
                wr(a, d);
            end else if (op == 1) begin
                rd("R4 R10 random read", AW'(($urandom % 10) * 4));
            end else begin
                int k = int'($urandom % NCMP);
                logic [31:0] fa;
                if (($urandom % 4) != 0)
                    fa = {3'b000, slot_m[k][28:2], 2'($urandom)};
                else
                    fa = $urandom;
                if (($urandom % 8) == 0) fa[31:29] = 3'($urandom);
                ft("R7 R8 R9 R11 random fetch", fa, ($urandom % 8) != 0);
            end
        end

        finish_run();
    end

endmodule